// File: doc/BRIEF.md
# Micro Translation Buffer

This block is a small first-level address translation cache that sits in front of one access port. Every request carries a virtual page number, a write flag and a user-mode flag. The page number is compared against every stored entry at once. On a hit the block returns the physical page number one cycle after it accepts the request. The same lookup checks the stored protection bits and reports an abort instead of a translation when the access is not allowed.

On a miss the block stops taking requests and raises a refill request toward the second-level buffer. It installs the reply and then repeats the lookup for the held request. Two events wipe the whole buffer: a pulse on the maintenance input, or a context-identifier write whose value differs from the current one. A parameter builds either the instruction-side variant or the data-side variant. The variant decides which protection rules apply and which abort output is used.

Top module: `utlb_micro`

## Requirements
- R1: After reset no entry is valid, `req_ready` is high, and `rsp_valid` and `refill_req` are low.
- R2: A request accepted while its page is present gives `rsp_valid` on the next cycle with the stored physical page, and no refill request is raised.
- R3: A request that misses is accepted, then `req_ready` drops and `refill_req` rises carrying the held page number. Exactly one reply is consumed and installed, and the response then carries the installed translation. A later access to that page hits.
- R4: In the data variant (`IS_INSTR`=0), a user access to a privileged page or a write to a read-only page sets `rsp_abort_data` with `rsp_ppn` zero. The execute-never bit is ignored.
- R5: In the instruction variant (`IS_INSTR`=1), a fetch from an execute-never page or a user fetch from a privileged page sets `rsp_abort_prefetch` with `rsp_ppn` zero. The write flag and the read-only bit are ignored, and `rsp_abort_data` stays low.
- R6: A pulse on `flush` invalidates every entry. A request accepted in the same cycle as the pulse is treated as a miss.
- R7: A `ctx_wr` whose `ctx_wdata` differs from the current context invalidates every entry. A write of the current value leaves every entry in place.
- R8: If a wipe occurs while a refill is outstanding, or in the cycle its reply arrives, that reply is discarded. `refill_req` stays high for a fresh reply, and the response comes from the fresh reply.
- R9: The buffer holds `ENTRIES` translations. A refill fills an invalid entry when one exists; otherwise a free-running counter picks the victim.
- R10: `refill_req` stays high with a stable `refill_vpn` until `refill_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block accepts a request this cycle |
| req_vpn | input | VPN_W | Virtual page number |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| rsp_valid | output | 1 | Response present |
| rsp_ppn | output | PPN_W | Translated physical page, zero on abort |
| rsp_abort_data | output | 1 | Data-side protection abort |
| rsp_abort_prefetch | output | 1 | Instruction-side protection abort |
| flush | input | 1 | Second-level maintenance pulse, wipes all entries |
| ctx_wr | input | 1 | Context identifier write strobe |
| ctx_wdata | input | CTX_W | New context identifier |
| refill_req | output | 1 | Refill wanted from the second level |
| refill_vpn | output | VPN_W | Page number to refill |
| refill_ack | input | 1 | Refill reply present, one cycle |
| refill_ppn | input | PPN_W | Physical page in reply |
| refill_priv | input | 1 | Reply page is privileged-only |
| refill_ro | input | 1 | Reply page is read-only |
| refill_xn | input | 1 | Reply page is execute-never |

## Verification
The bench raises `flush` in the very cycle a cached page is requested. A design that lets the stale entry hit would respond without consuming a refill. It also wipes the buffer halfway through an outstanding refill. A design that installs the stale reply would consume one refill where two are expected. Context writes of both an equal and a different value tell apart a design that flushes on every write from one that flushes on none. Filling all entries and reading them back exposes a victim choice that overwrites live entries while free ones remain. Protection combinations are driven through both variants, to catch a swapped abort output or a rule applied to the wrong side.

// File: rtl/utlb_pkg.sv
package utlb_pkg;
    typedef struct packed {
        logic priv;
        logic ro;
        logic xn;
    } perm_t;

    typedef enum logic [1:0] {
        ST_LOOK  = 2'd0,
        ST_MISS  = 2'd1,
        ST_RETRY = 2'd2
    } state_t;
endpackage

// File: rtl/utlb_cam.sv
module utlb_cam
    import utlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [VPN_W-1:0] wr_vpn_i,
    input  logic [PPN_W-1:0] wr_ppn_i,
    input  perm_t            wr_perm_i,
    input  logic [VPN_W-1:0] look_vpn_i,
    output logic             hit_o,
    output logic [PPN_W-1:0] hit_ppn_o,
    output perm_t            hit_perm_o,
    output logic             free_o,
    output logic [IDX_W-1:0] free_idx_o
);
    logic [ENTRIES-1:0] valid_d, valid_q;
    logic [VPN_W-1:0]   vpn_d  [ENTRIES];
    logic [VPN_W-1:0]   vpn_q  [ENTRIES];
    logic [PPN_W-1:0]   ppn_d  [ENTRIES];
    logic [PPN_W-1:0]   ppn_q  [ENTRIES];
    perm_t              perm_d [ENTRIES];
    perm_t              perm_q [ENTRIES];
    logic [ENTRIES-1:0] match;

    // one comparator per entry, all in parallel
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid_q[g] && (vpn_q[g] == look_vpn_i);
    end

    always_comb begin
        hit_o      = |match;
        hit_ppn_o  = '0;
        hit_perm_o = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                hit_ppn_o  = hit_ppn_o | ppn_q[i];
                hit_perm_o = hit_perm_o | perm_q[i];
            end
        end
        free_o     = ~&valid_q;
        free_idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_q[i]) free_idx_o = IDX_W'(i);
        end
    end

    always_comb begin
        valid_d = valid_q;
        vpn_d   = vpn_q;
        ppn_d   = ppn_q;
        perm_d  = perm_q;
        if (clear_i) begin
            valid_d = '0;
        end else if (wr_en_i) begin
            valid_d[wr_idx_i] = 1'b1;
            vpn_d[wr_idx_i]   = wr_vpn_i;
            ppn_d[wr_idx_i]   = wr_ppn_i;
            perm_d[wr_idx_i]  = wr_perm_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                vpn_q[i]  <= '0;
                ppn_q[i]  <= '0;
                perm_q[i] <= '0;
            end
        end else begin
            valid_q <= valid_d;
            vpn_q   <= vpn_d;
            ppn_q   <= ppn_d;
            perm_q  <= perm_d;
        end
    end
endmodule

// File: rtl/utlb_perm.sv
module utlb_perm
    import utlb_pkg::*;
#(
    parameter bit IS_INSTR = 1'b0
) (
    input  perm_t perm_i,
    input  logic  user_i,
    input  logic  write_i,
    output logic  fault_o
);
    logic priv_fault;
    logic data_fault;
    logic fetch_fault;

    assign priv_fault  = user_i & perm_i.priv;
    assign data_fault  = priv_fault | (write_i & perm_i.ro);
    assign fetch_fault = priv_fault | perm_i.xn;

    if (IS_INSTR) begin : g_fetch
        assign fault_o = fetch_fault;
    end else begin : g_data
        assign fault_o = data_fault;
    end
endmodule

// File: rtl/utlb_micro.sv
module utlb_micro
    import utlb_pkg::*;
#(
    parameter int ENTRIES  = 32,
    parameter int VPN_W    = 20,
    parameter int PPN_W    = 20,
    parameter int CTX_W    = 8,
    parameter bit IS_INSTR = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic             req_write,
    input  logic             req_user,
    output logic             rsp_valid,
    output logic [PPN_W-1:0] rsp_ppn,
    output logic             rsp_abort_data,
    output logic             rsp_abort_prefetch,
    input  logic             flush,
    input  logic             ctx_wr,
    input  logic [CTX_W-1:0] ctx_wdata,
    output logic             refill_req,
    output logic [VPN_W-1:0] refill_vpn,
    input  logic             refill_ack,
    input  logic [PPN_W-1:0] refill_ppn,
    input  logic             refill_priv,
    input  logic             refill_ro,
    input  logic             refill_xn
);
    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        state_t             st;
        logic               discard;
        logic [IDX_W-1:0]   ctr;
        logic [CTX_W-1:0]   ctx;
        logic [VPN_W-1:0]   vpn;
        logic               write;
        logic               user;
        logic               rsp_v;
        logic               rsp_flt;
        logic [PPN_W-1:0]   rsp_ppn;
    } regs_t;

    regs_t q, d;

    logic             wipe;
    logic [VPN_W-1:0] look_vpn;
    logic             look_user, look_write;
    logic             hit, hit_eff, fault, free;
    logic [PPN_W-1:0] hit_ppn;
    perm_t            hit_perm, fill_perm;
    logic [IDX_W-1:0] free_idx, victim;
    logic             cam_wr;

    assign wipe       = flush | (ctx_wr && (ctx_wdata != q.ctx));
    assign look_vpn   = (q.st == ST_LOOK) ? req_vpn   : q.vpn;
    assign look_user  = (q.st == ST_LOOK) ? req_user  : q.user;
    assign look_write = (q.st == ST_LOOK) ? req_write : q.write;
    assign hit_eff    = hit & ~wipe;
    assign victim     = free ? free_idx : q.ctr;
    assign fill_perm  = '{priv: refill_priv, ro: refill_ro, xn: refill_xn};

    utlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_cam (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (wipe),
        .wr_en_i    (cam_wr),
        .wr_idx_i   (victim),
        .wr_vpn_i   (q.vpn),
        .wr_ppn_i   (refill_ppn),
        .wr_perm_i  (fill_perm),
        .look_vpn_i (look_vpn),
        .hit_o      (hit),
        .hit_ppn_o  (hit_ppn),
        .hit_perm_o (hit_perm),
        .free_o     (free),
        .free_idx_o (free_idx)
    );

    utlb_perm #(.IS_INSTR(IS_INSTR)) u_perm (
        .perm_i  (hit_perm),
        .user_i  (look_user),
        .write_i (look_write),
        .fault_o (fault)
    );

    always_comb begin
        d         = q;
        cam_wr    = 1'b0;
        d.rsp_v   = 1'b0;
        d.rsp_flt = 1'b0;
        d.rsp_ppn = '0;
        d.ctr     = (q.ctr == IDX_W'(ENTRIES - 1)) ? '0 : q.ctr + 1'b1;
        if (ctx_wr) d.ctx = ctx_wdata;
        unique case (q.st)
            ST_LOOK: begin
                if (req_valid) begin
                    d.vpn   = req_vpn;
                    d.write = req_write;
                    d.user  = req_user;
                    if (hit_eff) begin
                        d.rsp_v   = 1'b1;
                        d.rsp_flt = fault;
                        d.rsp_ppn = fault ? '0 : hit_ppn;
                    end else begin
                        d.st      = ST_MISS;
                        d.discard = 1'b0;
                    end
                end
            end
            ST_MISS: begin
                if (refill_ack) begin
                    if (wipe || q.discard) begin
                        d.discard = 1'b0;
                    end else begin
                        cam_wr = 1'b1;
                        d.st   = ST_RETRY;
                    end
                end else if (wipe) begin
                    d.discard = 1'b1;
                end
            end
            ST_RETRY: begin
                if (hit_eff) begin
                    d.rsp_v   = 1'b1;
                    d.rsp_flt = fault;
                    d.rsp_ppn = fault ? '0 : hit_ppn;
                    d.st      = ST_LOOK;
                end else begin
                    d.st      = ST_MISS;
                    d.discard = 1'b0;
                end
            end
            default: d.st = ST_LOOK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_LOOK;
        end else begin
            q <= d;
        end
    end

    assign req_ready          = (q.st == ST_LOOK);
    assign refill_req         = (q.st == ST_MISS);
    assign refill_vpn         = q.vpn;
    assign rsp_valid          = q.rsp_v;
    assign rsp_ppn            = q.rsp_ppn;
    assign rsp_abort_data     = IS_INSTR ? 1'b0 : q.rsp_flt;
    assign rsp_abort_prefetch = IS_INSTR ? q.rsp_flt : 1'b0;
endmodule

// File: rtl/utlb_micro_chk.sv
module utlb_micro_chk #(
    parameter int VPN_W = 20,
    parameter int PPN_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic [PPN_W-1:0] rsp_ppn,
    input logic             rsp_abort_data,
    input logic             rsp_abort_prefetch,
    input logic             flush,
    input logic             refill_req,
    input logic [VPN_W-1:0] refill_vpn,
    input logic             refill_ack
);
    p_stall_in_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req |-> !req_ready);

    p_refill_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_req && !refill_ack) |=> (refill_req && $stable(refill_vpn)));

    p_abort_zero_ppn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_abort_data || rsp_abort_prefetch) |-> (rsp_valid && rsp_ppn == '0));

    p_single_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_abort_data && rsp_abort_prefetch));

    p_rsp_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(req_valid && req_ready) || $past(refill_ack, 2)));

    p_flush_forces_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && req_valid && req_ready) |=> !rsp_valid);
endmodule

bind utlb_micro utlb_micro_chk #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_chk (
    .clk                (clk),
    .rst_n              (rst_n),
    .req_valid          (req_valid),
    .req_ready          (req_ready),
    .rsp_valid          (rsp_valid),
    .rsp_ppn            (rsp_ppn),
    .rsp_abort_data     (rsp_abort_data),
    .rsp_abort_prefetch (rsp_abort_prefetch),
    .flush              (flush),
    .refill_req         (refill_req),
    .refill_vpn         (refill_vpn),
    .refill_ack         (refill_ack)
);

// File: tb/sim_utlb_micro.sv
module sim_refill_model #(
    parameter int VPN_W = 20,
    parameter int PPN_W = 20,
    parameter int LAT   = 4
) (
    input  logic             clk,
    input  logic             req,
    input  logic [VPN_W-1:0] vpn,
    output logic             ack,
    output logic [PPN_W-1:0] ppn,
    output logic             priv,
    output logic             ro,
    output logic             xn,
    output int               served
);
    initial begin
        int cnt;
        cnt = 0; ack = 0; ppn = '0; priv = 0; ro = 0; xn = 0; served = 0;
        forever begin
            @(negedge clk);
            if (ack) begin
                ack = 0;
                cnt = 0;
            end else if (req) begin
                cnt = cnt + 1;
                if (cnt == LAT) begin
                    ack    = 1;
                    ppn    = PPN_W'(vpn) ^ PPN_W'(20'h53C9A);
                    priv   = vpn[0];
                    ro     = vpn[1];
                    xn     = vpn[2];
                    served = served + 1;
                    cnt    = 0;
                end
            end else begin
                cnt = 0;
            end
        end
    end
endmodule

module sim_utlb_micro;
    localparam int CLK_PERIOD = 10;
    localparam int VW = 20;
    localparam int PW = 20;
    localparam int CW = 8;

    typedef struct {
        logic [PW-1:0] ppn;
        bit            ab;
        string         tag;
    } exp_t;

    logic clk = 0;
    logic rst_n = 0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int total = 0;
    int bad = 0;
    bit done = 0;
    exp_t q0[$];
    exp_t q1[$];

    // data-side instance signals
    logic          d_valid = 0, d_write = 0, d_user = 0, d_flush = 0, d_ctx_wr = 0;
    logic [VW-1:0] d_vpn = '0;
    logic [CW-1:0] d_ctx = '0;
    logic          d_ready, d_rsp_v, d_ab_d, d_ab_p, d_rreq, d_ack, d_priv, d_ro, d_xn;
    logic [PW-1:0] d_ppn, d_fppn;
    logic [VW-1:0] d_rvpn;
    int            d_served;

    // instruction-side instance signals
    logic          i_valid = 0, i_write = 0, i_user = 0;
    logic [VW-1:0] i_vpn = '0;
    logic          i_ready, i_rsp_v, i_ab_d, i_ab_p, i_rreq, i_ack, i_priv, i_ro, i_xn;
    logic [PW-1:0] i_ppn, i_fppn;
    logic [VW-1:0] i_rvpn;
    int            i_served;

    utlb_micro #(.VPN_W(VW), .PPN_W(PW), .CTX_W(CW), .IS_INSTR(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(d_valid), .req_ready(d_ready),
        .req_vpn(d_vpn), .req_write(d_write), .req_user(d_user),
        .rsp_valid(d_rsp_v), .rsp_ppn(d_ppn), .rsp_abort_data(d_ab_d),
        .rsp_abort_prefetch(d_ab_p), .flush(d_flush), .ctx_wr(d_ctx_wr),
        .ctx_wdata(d_ctx), .refill_req(d_rreq), .refill_vpn(d_rvpn),
        .refill_ack(d_ack), .refill_ppn(d_fppn), .refill_priv(d_priv),
        .refill_ro(d_ro), .refill_xn(d_xn));

    sim_refill_model #(.VPN_W(VW), .PPN_W(PW)) m0 (
        .clk(clk), .req(d_rreq), .vpn(d_rvpn), .ack(d_ack), .ppn(d_fppn),
        .priv(d_priv), .ro(d_ro), .xn(d_xn), .served(d_served));

    utlb_micro #(.VPN_W(VW), .PPN_W(PW), .CTX_W(CW), .IS_INSTR(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(i_valid), .req_ready(i_ready),
        .req_vpn(i_vpn), .req_write(i_write), .req_user(i_user),
        .rsp_valid(i_rsp_v), .rsp_ppn(i_ppn), .rsp_abort_data(i_ab_d),
        .rsp_abort_prefetch(i_ab_p), .flush(1'b0), .ctx_wr(1'b0),
        .ctx_wdata('0), .refill_req(i_rreq), .refill_vpn(i_rvpn),
        .refill_ack(i_ack), .refill_ppn(i_fppn), .refill_priv(i_priv),
        .refill_ro(i_ro), .refill_xn(i_xn));

    sim_refill_model #(.VPN_W(VW), .PPN_W(PW)) m1 (
        .clk(clk), .req(i_rreq), .vpn(i_rvpn), .ack(i_ack), .ppn(i_fppn),
        .priv(i_priv), .ro(i_ro), .xn(i_xn), .served(i_served));

    // page table of the bench: ppn = vpn ^ 53C9A, bit0 priv, bit1 ro, bit2 xn
    function automatic logic [PW-1:0] tbl_ppn(input logic [VW-1:0] v);
        return PW'(v) ^ PW'(20'h53C9A);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic iss0(input logic [VW-1:0] v, input bit wr, input bit usr, input string tag);
        exp_t e;
        bit f;
        f = (usr && v[0]) || (wr && v[1]);
        e.ppn = f ? '0 : tbl_ppn(v);
        e.ab  = f;
        e.tag = tag;
        q0.push_back(e);
        @(negedge clk);
        d_valid = 1; d_vpn = v; d_write = wr; d_user = usr;
        while (!d_ready) @(negedge clk);
        @(negedge clk);
        d_valid = 0;
    endtask

    task automatic iss1(input logic [VW-1:0] v, input bit wr, input bit usr, input string tag);
        exp_t e;
        bit f;
        f = (usr && v[0]) || v[2];
        e.ppn = f ? '0 : tbl_ppn(v);
        e.ab  = f;
        e.tag = tag;
        q1.push_back(e);
        @(negedge clk);
        i_valid = 1; i_vpn = v; i_write = wr; i_user = usr;
        while (!i_ready) @(negedge clk);
        @(negedge clk);
        i_valid = 0;
    endtask

    task automatic drain();
        while (q0.size() != 0 || q1.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic ctx_write(input logic [CW-1:0] val);
        @(negedge clk);
        d_ctx_wr = 1; d_ctx = val;
        @(negedge clk);
        d_ctx_wr = 0;
    endtask

    // monitors: pop the expected item as each response appears
    always @(negedge clk) begin
        if (rst_n && d_rsp_v) begin
            total++;
            if (q0.size() == 0) begin
                bad++;
                $display("FAIL R2 unexpected data response actual=%0h expected=none", d_ppn);
            end else begin
                exp_t e;
                e = q0.pop_front();
                if (d_ppn !== e.ppn || d_ab_d !== e.ab || d_ab_p !== 1'b0) begin
                    bad++;
                    $display("FAIL %s ppn/abort_d/abort_p actual=%0h/%0b/%0b expected=%0h/%0b/0",
                             e.tag, d_ppn, d_ab_d, d_ab_p, e.ppn, e.ab);
                end
            end
        end
        if (rst_n && i_rsp_v) begin
            total++;
            if (q1.size() == 0) begin
                bad++;
                $display("FAIL R5 unexpected fetch response actual=%0h expected=none", i_ppn);
            end else begin
                exp_t e;
                e = q1.pop_front();
                if (i_ppn !== e.ppn || i_ab_p !== e.ab || i_ab_d !== 1'b0) begin
                    bad++;
                    $display("FAIL %s ppn/abort_p/abort_d actual=%0h/%0b/%0b expected=%0h/%0b/0",
                             e.tag, i_ppn, i_ab_p, i_ab_d, e.ppn, e.ab);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(d_ready === 1'b1, "R1", "ready", d_ready, 1);
        chk(d_rsp_v === 1'b0 && d_rreq === 1'b0, "R1", "rsp/refill", {d_rsp_v, d_rreq}, 0);
        chk(i_ready === 1'b1 && i_rreq === 1'b0, "R1", "instr ready/refill", {i_ready, i_rreq}, 2);

        // R3: miss, stall, single refill, install
        base = d_served;
        iss0(20'h00008, 0, 0, "R3 miss fill");
        chk(d_ready === 1'b0 && d_rreq === 1'b1, "R3", "stall during miss", {d_ready, d_rreq}, 1);
        chk(d_rvpn === 20'h00008, "R10", "refill_vpn", d_rvpn, 20'h8);
        drain();
        chk(d_served - base == 1, "R3", "refill count", d_served - base, 1);

        // R2: hit without refill
        base = d_served;
        iss0(20'h00008, 1, 1, "R2 hit");
        iss0(20'h00008, 0, 1, "R2 hit again");
        drain();
        chk(d_served - base == 0, "R2", "refill count on hits", d_served - base, 0);

        // R4: data protection rules
        iss0(20'h00011, 0, 1, "R4 user to priv");
        iss0(20'h00011, 0, 0, "R4 kernel to priv");
        iss0(20'h00012, 1, 0, "R4 write to ro");
        iss0(20'h00012, 0, 1, "R4 read of ro");
        iss0(20'h00014, 1, 1, "R4 xn ignored on data");
        iss0(20'h00017, 1, 0, "R4 write ro priv kernel");
        drain();

        // R6: flush pulse wipes everything
        @(negedge clk); d_flush = 1; @(negedge clk); d_flush = 0;
        base = d_served;
        iss0(20'h00008, 0, 0, "R6 after flush");
        drain();
        chk(d_served - base == 1, "R6", "refill after flush", d_served - base, 1);
        base = d_served;
        fork
            iss0(20'h00008, 0, 0, "R6 same-cycle flush");
            begin @(negedge clk); d_flush = 1; @(negedge clk); d_flush = 0; end
        join
        drain();
        chk(d_served - base == 1, "R6", "same-cycle flush forces miss", d_served - base, 1);

        // R7: context writes
        base = d_served;
        ctx_write(8'h00);
        iss0(20'h00008, 0, 0, "R7 same ctx keeps");
        drain();
        chk(d_served - base == 0, "R7", "refills after same ctx", d_served - base, 0);
        base = d_served;
        ctx_write(8'h3C);
        iss0(20'h00008, 0, 0, "R7 new ctx flushes");
        drain();
        chk(d_served - base == 1, "R7", "refills after new ctx", d_served - base, 1);

        // R8: wipe while refill outstanding
        base = d_served;
        fork
            iss0(20'h00030, 0, 0, "R8 flush during miss");
            begin repeat (3) @(negedge clk); d_flush = 1; @(negedge clk); d_flush = 0; end
        join
        drain();
        chk(d_served - base == 2, "R8", "discard and reissue", d_served - base, 2);

        // R9: capacity of 32, free entries filled first
        @(negedge clk); d_flush = 1; @(negedge clk); d_flush = 0;
        base = d_served;
        for (int k = 0; k < 32; k++) iss0(VW'(32'h100 + k * 8), 0, 0, "R9 fill");
        drain();
        chk(d_served - base == 32, "R9", "fill refills", d_served - base, 32);
        base = d_served;
        for (int k = 0; k < 32; k++) iss0(VW'(32'h100 + k * 8), 0, 0, "R9 all resident");
        drain();
        chk(d_served - base == 0, "R9", "refills with full buffer", d_served - base, 0);
        base = d_served;
        iss0(20'h00800, 0, 0, "R9 eviction fill");
        drain();
        chk(d_served - base == 1, "R9", "refill on eviction", d_served - base, 1);

        // R5: instruction variant
        base = i_served;
        iss1(20'h00004, 0, 0, "R5 fetch xn");
        iss1(20'h00001, 0, 1, "R5 user fetch priv");
        iss1(20'h00001, 0, 0, "R5 kernel fetch priv");
        iss1(20'h00002, 1, 1, "R5 ro and write ignored");
        iss1(20'h00004, 0, 0, "R5 xn hit");
        drain();
        chk(i_served - base == 3, "R5", "instr refills", i_served - base, 3);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule